// File: doc/BRIEF.md
# Ethernet PHY Link Status Poller

This block works out the link state of a single Ethernet port. At a programmable interval it reads the status of an external PHY through a simple register-read port. A separate serial management engine, which is not part of this block, carries that port to the wire. A strap picks one of two PHY status register layouts. In the standard layout one or two reads are needed. In the alternate layout a single read is enough.

A port with no management-capable PHY is marked by a configuration flag. For such a port the block uses the in-band status bits recovered from the receive path when in-band status is enabled. When it is not enabled, the link is reported as down.

The decoded state appears on three registered outputs: link up, full duplex and a 2-bit speed code. It changes only together with a one-cycle update strobe, which marks the end of each completed poll. Between polls the outputs hold their values. A poll timer tick that comes while a poll is still running is dropped.

Top module: `lsp_link_poller`

## Requirements
- R1: While reset is applied and on the first cycle after it, link_up, full_duplex, speed, update and mdio_req are all 0.
- R2: The poll timer ticks every cfg_interval+1 cycles. When the block is idle, a tick starts a poll. A tick that arrives while a poll is running is ignored, so the spacing between updates is always a whole multiple of cfg_interval+1.
- R3: A read request presents mdio_bus = cfg_phy_addr[15:8], mdio_phy = cfg_phy_addr[7:0] and a register number on mdio_reg. mdio_req and these fields stay stable until mdio_ack. No new request is made until the read data for the previous one has arrived with mdio_rvalid.
- R4: In the standard layout (cfg_alt_layout=0), register 17 is read first. Register 0 is read second, and only if bit 11 of register 17 is 0.
- R5: In the standard layout, the status counts as resolved if register 17 bit 11 is 1, or if register 0 bit 12 (auto-negotiation enable) is 0. An unresolved status gives link_up=0, full_duplex=0, speed=0.
- R6: A resolved standard status gives link_up=1 and full_duplex = register 17 bit 13. The speed is taken from register 17 bits 15:14 (0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s). Code 3 drives every output to 0. The speed output never shows 3.
- R7: In the alternate layout (cfg_alt_layout=1), only register 25 is read. Its bits 10:8 decode as: 0 down, 1 10/half, 2 10/full, 3 100/half, 4 and 5 100/full, 6 1000/half, 7 1000/full.
- R8: With cfg_no_phy=1 and cfg_inband_en=1, link_up copies ib_link and full_duplex copies ib_duplex. speed copies ib_speed, which uses the same 0/1/2 encoding; an ib_speed of 3 drives every output to 0.
- R9: With cfg_no_phy=1, no read request is issued. If cfg_inband_en=0 as well, the link is reported down with all outputs 0.
- R10: Whenever link_up is 0, full_duplex and speed are 0.
- R11: update is high for exactly one cycle after each completed poll. The outputs change only in the cycle where update is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | INTERVAL_W | Poll period minus one, in cycles |
| cfg_phy_addr | input | 16 | Bus number in [15:8], PHY address in [7:0] |
| cfg_no_phy | input | 1 | Port has no management-capable PHY |
| cfg_alt_layout | input | 1 | Strap: 0 standard layout, 1 alternate layout |
| cfg_inband_en | input | 1 | In-band status is available for a PHY-less port |
| ib_link | input | 1 | In-band link status |
| ib_duplex | input | 1 | In-band duplex |
| ib_speed | input | 2 | In-band speed code |
| mdio_req | output | 1 | Read request, held until acknowledged |
| mdio_bus | output | 8 | Bus number of the request |
| mdio_phy | output | 8 | PHY address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_ack | input | 1 | Request accepted |
| mdio_rvalid | input | 1 | Read data valid pulse |
| mdio_rdata | input | 16 | Read data |
| link_up | output | 1 | Link is up |
| full_duplex | output | 1 | Full duplex |
| speed | output | 2 | 0 = 10, 1 = 100, 2 = 1000 Mb/s |
| update | output | 1 | One-cycle strobe when a poll completes |

## Verification
Some properties are checked by the assertions on every cycle:
- a down link always carries zero duplex and speed;
- speed code 3 never appears;
- update lasts a single cycle;
- the outputs move only with update;
- a request holds its fields until it is acknowledged.

The bench's scenarios are needed for everything that depends on what the PHY returns:
- decoding every register 17 field combination, including the forced-resolve path through register 0;
- each of the eight alternate-layout codes;
- all in-band combinations;
- which registers a poll actually reads;
- the update spacing set by the poll timer, when the block is idle and when it is busy.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
   localparam int unsigned MDIO_DW = 16;
   localparam int unsigned MDIO_RW = 5;
   localparam int unsigned BUS_W   = 8;
   localparam int unsigned PHY_W   = 8;
   localparam int unsigned ADDR_W  = BUS_W + PHY_W;

   // register numbers used by the poll sequence
   localparam logic [MDIO_RW-1:0] REG_CTRL     = 5'd0;
   localparam logic [MDIO_RW-1:0] REG_STAT_STD = 5'd17;
   localparam logic [MDIO_RW-1:0] REG_STAT_ALT = 5'd25;

   // bit positions in the standard layout
   localparam int unsigned BIT_RESOLVED = 11;
   localparam int unsigned BIT_ANEG_EN  = 12;
   localparam int unsigned BIT_DUPLEX   = 13;
   localparam int unsigned BIT_SPD_LO   = 14;
   // field position in the alternate layout
   localparam int unsigned ALT_LO       = 8;

   localparam logic [1:0] SPD_10   = 2'd0;
   localparam logic [1:0] SPD_100  = 2'd1;
   localparam logic [1:0] SPD_1000 = 2'd2;
   localparam logic [1:0] SPD_BAD  = 2'd3;

   typedef struct packed {
      logic       up;
      logic       fdx;
      logic [1:0] spd;
   } lsp_link_t;

   localparam lsp_link_t LINK_DOWN = '0;

   typedef enum logic [2:0] {
      S_IDLE,
      S_REQ_ST,
      S_WAIT_ST,
      S_REQ_CT,
      S_WAIT_CT,
      S_FIN
   } lsp_state_e;
endpackage

// File: rtl/lsp_poll_timer.sv
module lsp_poll_timer #(
   parameter int unsigned INTERVAL_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [INTERVAL_W-1:0] cfg_interval,
   output logic                  tick
);
   initial begin
      assert (INTERVAL_W >= 1 && INTERVAL_W <= 32)
         else $error("lsp_poll_timer: INTERVAL_W out of range");
   end

   logic [INTERVAL_W-1:0] cnt_q;

   // free-running: one tick per cfg_interval+1 cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q >= cfg_interval) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end
endmodule

// File: rtl/lsp_mdio_seq.sv
module lsp_mdio_seq
   import lsp_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [ADDR_W-1:0]    cfg_phy_addr,
   input  logic                 cfg_no_phy,
   input  logic                 cfg_alt_layout,
   input  logic                 cfg_inband_en,
   output logic                 mdio_req,
   output logic [BUS_W-1:0]     mdio_bus,
   output logic [PHY_W-1:0]     mdio_phy,
   output logic [MDIO_RW-1:0]   mdio_reg,
   input  logic                 mdio_ack,
   input  logic                 mdio_rvalid,
   input  logic [MDIO_DW-1:0]   mdio_rdata,
   output logic [MDIO_DW-1:0]   stat_o,
   output logic                 alt_o,
   output logic                 nophy_o,
   output logic                 ib_en_o,
   output logic                 done_o
);
   lsp_state_e          st_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                alt_q;
   logic                nophy_q;
   logic                ib_en_q;
   logic [MDIO_DW-1:0]  stat_q;

   // a tick is only looked at in S_IDLE; in any other state it is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         addr_q  <= '0;
         alt_q   <= 1'b0;
         nophy_q <= 1'b0;
         ib_en_q <= 1'b0;
         stat_q  <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (tick) begin
                  addr_q  <= cfg_phy_addr;
                  alt_q   <= cfg_alt_layout;
                  nophy_q <= cfg_no_phy;
                  ib_en_q <= cfg_inband_en;
                  st_q    <= cfg_no_phy ? S_FIN : S_REQ_ST;
               end
            end
            S_REQ_ST: begin
               if (mdio_ack) st_q <= S_WAIT_ST;
            end
            S_WAIT_ST: begin
               if (mdio_rvalid) begin
                  stat_q <= mdio_rdata;
                  if (alt_q || mdio_rdata[BIT_RESOLVED]) st_q <= S_FIN;
                  else                                   st_q <= S_REQ_CT;
               end
            end
            S_REQ_CT: begin
               if (mdio_ack) st_q <= S_WAIT_CT;
            end
            S_WAIT_CT: begin
               if (mdio_rvalid) begin
                  // auto-negotiation off: resolve bit is forced
                  if (!mdio_rdata[BIT_ANEG_EN]) stat_q[BIT_RESOLVED] <= 1'b1;
                  st_q <= S_FIN;
               end
            end
            S_FIN:   st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mdio_req = (st_q == S_REQ_ST) || (st_q == S_REQ_CT);
      mdio_bus = addr_q[ADDR_W-1:PHY_W];
      mdio_phy = addr_q[PHY_W-1:0];
      if (st_q == S_REQ_CT)  mdio_reg = REG_CTRL;
      else if (alt_q)        mdio_reg = REG_STAT_ALT;
      else                   mdio_reg = REG_STAT_STD;
   end

   assign stat_o  = stat_q;
   assign alt_o   = alt_q;
   assign nophy_o = nophy_q;
   assign ib_en_o = ib_en_q;
   assign done_o  = (st_q == S_FIN);
endmodule

// File: rtl/lsp_status_decode.sv
module lsp_status_decode
   import lsp_pkg::*;
(
   input  logic [MDIO_DW-1:0] stat,
   input  logic               alt,
   input  logic               nophy,
   input  logic               ib_en,
   input  logic               ib_link,
   input  logic               ib_duplex,
   input  logic [1:0]         ib_speed,
   output lsp_link_t          link
);
   function automatic lsp_link_t dec_std(input logic [MDIO_DW-1:0] w);
      lsp_link_t r;
      r = LINK_DOWN;
      if (w[BIT_RESOLVED] && (w[BIT_SPD_LO+1:BIT_SPD_LO] != SPD_BAD)) begin
         r.up  = 1'b1;
         r.fdx = w[BIT_DUPLEX];
         r.spd = w[BIT_SPD_LO+1:BIT_SPD_LO];
      end
      return r;
   endfunction

   function automatic lsp_link_t dec_alt(input logic [2:0] c);
      lsp_link_t r;
      unique case (c)
         3'd0:    r = LINK_DOWN;
         3'd1:    r = '{up: 1'b1, fdx: 1'b0, spd: SPD_10};
         3'd2:    r = '{up: 1'b1, fdx: 1'b1, spd: SPD_10};
         3'd3:    r = '{up: 1'b1, fdx: 1'b0, spd: SPD_100};
         3'd4,
         3'd5:    r = '{up: 1'b1, fdx: 1'b1, spd: SPD_100};
         3'd6:    r = '{up: 1'b1, fdx: 1'b0, spd: SPD_1000};
         default: r = '{up: 1'b1, fdx: 1'b1, spd: SPD_1000};
      endcase
      return r;
   endfunction

   lsp_link_t raw;
   logic      unused_bits;
   assign unused_bits = ^{stat[BIT_ANEG_EN], stat[ALT_LO-1:0]};

   always_comb begin
      if (nophy) begin
         if (ib_en && ib_link && (ib_speed != SPD_BAD))
            raw = '{up: 1'b1, fdx: ib_duplex, spd: ib_speed};
         else
            raw = LINK_DOWN;
      end else if (alt) begin
         raw = dec_alt(stat[ALT_LO+2:ALT_LO]);
      end else begin
         raw = dec_std(stat);
      end
      // a down link never carries duplex or speed
      link = raw.up ? raw : LINK_DOWN;
   end
endmodule

// File: rtl/lsp_link_poller.sv
module lsp_link_poller
   import lsp_pkg::*;
#(
   parameter int unsigned INTERVAL_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [INTERVAL_W-1:0] cfg_interval,
   input  logic [15:0]           cfg_phy_addr,
   input  logic                  cfg_no_phy,
   input  logic                  cfg_alt_layout,
   input  logic                  cfg_inband_en,
   input  logic                  ib_link,
   input  logic                  ib_duplex,
   input  logic [1:0]            ib_speed,
   output logic                  mdio_req,
   output logic [7:0]            mdio_bus,
   output logic [7:0]            mdio_phy,
   output logic [4:0]            mdio_reg,
   input  logic                  mdio_ack,
   input  logic                  mdio_rvalid,
   input  logic [15:0]           mdio_rdata,
   output logic                  link_up,
   output logic                  full_duplex,
   output logic [1:0]            speed,
   output logic                  update
);
   initial begin
      assert (ADDR_W == 16 && MDIO_DW == 16 && MDIO_RW == 5)
         else $error("lsp_link_poller: package widths do not match ports");
   end

   logic               tick;
   logic [MDIO_DW-1:0] stat;
   logic               alt_q, nophy_q, ib_en_q, seq_done;
   lsp_link_t          dec_link, link_q;
   logic               upd_q;

   lsp_poll_timer #(.INTERVAL_W(INTERVAL_W)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_interval (cfg_interval),
      .tick         (tick)
   );

   lsp_mdio_seq u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick           (tick),
      .cfg_phy_addr   (cfg_phy_addr),
      .cfg_no_phy     (cfg_no_phy),
      .cfg_alt_layout (cfg_alt_layout),
      .cfg_inband_en  (cfg_inband_en),
      .mdio_req       (mdio_req),
      .mdio_bus       (mdio_bus),
      .mdio_phy       (mdio_phy),
      .mdio_reg       (mdio_reg),
      .mdio_ack       (mdio_ack),
      .mdio_rvalid    (mdio_rvalid),
      .mdio_rdata     (mdio_rdata),
      .stat_o         (stat),
      .alt_o          (alt_q),
      .nophy_o        (nophy_q),
      .ib_en_o        (ib_en_q),
      .done_o         (seq_done)
   );

   lsp_status_decode u_dec (
      .stat      (stat),
      .alt       (alt_q),
      .nophy     (nophy_q),
      .ib_en     (ib_en_q),
      .ib_link   (ib_link),
      .ib_duplex (ib_duplex),
      .ib_speed  (ib_speed),
      .link      (dec_link)
   );

   // outputs load only at the end of a poll, together with the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q <= LINK_DOWN;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= seq_done;
         if (seq_done) link_q <= dec_link;
      end
   end

   assign link_up     = link_q.up;
   assign full_duplex = link_q.fdx;
   assign speed       = link_q.spd;
   assign update      = upd_q;
endmodule

// File: rtl/lsp_link_poller_chk.sv
module lsp_link_poller_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mdio_req,
   input logic       mdio_ack,
   input logic [7:0] mdio_bus,
   input logic [7:0] mdio_phy,
   input logic [4:0] mdio_reg,
   input logic       link_up,
   input logic       full_duplex,
   input logic [1:0] speed,
   input logic       update
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      $rose(rst_n) |-> (!update && !link_up && !full_duplex && speed == 2'd0 && !mdio_req));

   a_r10_down_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |-> (!full_duplex && speed == 2'd0));

   a_r6_no_bad_speed: assert property (@(posedge clk) disable iff (!rst_n)
      speed != 2'd3);

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      update |=> !update);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !update |-> $stable({link_up, full_duplex, speed}));

   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req && !mdio_ack) |=> (mdio_req && $stable({mdio_bus, mdio_phy, mdio_reg})));
endmodule

bind lsp_link_poller lsp_link_poller_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mdio_req    (mdio_req),
   .mdio_ack    (mdio_ack),
   .mdio_bus    (mdio_bus),
   .mdio_phy    (mdio_phy),
   .mdio_reg    (mdio_reg),
   .link_up     (link_up),
   .full_duplex (full_duplex),
   .speed       (speed),
   .update      (update)
);

// File: tb/tb_lsp_link_poller.sv
`timescale 1ns/1ps
module tb_lsp_link_poller;
   localparam int IW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] cfg_interval = 8'd15;
   logic [15:0]   cfg_phy_addr = 16'h3A05;
   logic          cfg_no_phy = 1'b0, cfg_alt_layout = 1'b0, cfg_inband_en = 1'b0;
   logic          ib_link = 1'b0, ib_duplex = 1'b0;
   logic [1:0]    ib_speed = 2'd0;
   logic          mdio_req, mdio_ack = 1'b0, mdio_rvalid = 1'b0;
   logic [7:0]    mdio_bus, mdio_phy;
   logic [4:0]    mdio_reg;
   logic [15:0]   mdio_rdata = 16'h0;
   logic          link_up, full_duplex, update;
   logic [1:0]    speed;

   always #4 clk = ~clk;

   lsp_link_poller #(.INTERVAL_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_phy_addr(cfg_phy_addr),
      .cfg_no_phy(cfg_no_phy), .cfg_alt_layout(cfg_alt_layout), .cfg_inband_en(cfg_inband_en),
      .ib_link(ib_link), .ib_duplex(ib_duplex), .ib_speed(ib_speed),
      .mdio_req(mdio_req), .mdio_bus(mdio_bus), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
      .mdio_ack(mdio_ack), .mdio_rvalid(mdio_rvalid), .mdio_rdata(mdio_rdata),
      .link_up(link_up), .full_duplex(full_duplex), .speed(speed), .update(update)
   );

   int errors = 0, checks = 0;
   bit finished = 0;

   // PHY register model
   logic [15:0] phy_r17 = 16'h0, phy_r0 = 16'h0, phy_r25 = 16'h0;
   int lat = 1;

   function automatic logic [15:0] regval(input logic [4:0] r);
      case (r)
         5'd0:    return phy_r0;
         5'd17:   return phy_r17;
         5'd25:   return phy_r25;
         default: return 16'hDEAD;
      endcase
   endfunction

   // monitor + responder state
   longint cyc = 0, upd_last = -100, upd_gap = 0;
   int  upd_cnt = 0, nreads = 0, hold_viol = 0, pulse_viol = 0, overlap_viol = 0;
   bit  pend = 0;
   int  lat_cnt = 0;
   logic [4:0] pend_reg = 5'd0;
   logic [4:0] rd_reg0 = 5'd0, rd_reg1 = 5'd0;
   logic [7:0] seen_bus = 8'h0, seen_phy = 8'h0;
   logic [3:0] prev_out = 4'h0, snap_out = 4'h0;
   int  snap_n = 0;
   logic [4:0] snap_r0 = 5'd0, snap_r1 = 5'd0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!update && ({link_up, full_duplex, speed} != prev_out)) hold_viol++;
         prev_out = {link_up, full_duplex, speed};
         if (update) begin
            if (upd_last == cyc - 1) pulse_viol++;
            upd_gap  = cyc - upd_last;
            upd_last = cyc;
            snap_out = {link_up, full_duplex, speed};
            snap_n = nreads; snap_r0 = rd_reg0; snap_r1 = rd_reg1;
            nreads = 0;
            upd_cnt++;
         end
         mdio_ack = 1'b0;
         mdio_rvalid = 1'b0;
         if (pend) begin
            if (mdio_req) overlap_viol++;
            if (lat_cnt == 0) begin
               mdio_rvalid = 1'b1;
               mdio_rdata  = regval(pend_reg);
               pend = 0;
            end else lat_cnt--;
         end else if (mdio_req) begin
            mdio_ack = 1'b1;
            pend = 1; lat_cnt = lat; pend_reg = mdio_reg;
            if (nreads == 0) rd_reg0 = mdio_reg;
            if (nreads == 1) rd_reg1 = mdio_reg;
            nreads++;
            seen_bus = mdio_bus; seen_phy = mdio_phy;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_upd();
      int n;
      n = upd_cnt;
      while (upd_cnt == n) @(posedge clk);
      #1;
   endtask

   // flush the poll that may have started with the old settings, then take the next
   task automatic settle();
      wait_upd();
      wait_upd();
   endtask

   function automatic logic [3:0] exp_std(input logic [15:0] r17, input logic [15:0] r0);
      logic res;
      res = r17[11] | ~r0[12];
      if (res && r17[15:14] != 2'd3) return {1'b1, r17[13], r17[15:14]};
      return 4'h0;
   endfunction

   function automatic logic [3:0] exp_alt(input int c);
      logic [1:0] s;
      logic f;
      if (c == 0) return 4'h0;
      s = (c <= 2) ? 2'd0 : (c <= 5) ? 2'd1 : 2'd2;
      f = (c == 2) || (c == 4) || (c == 5) || (c == 7);
      return {1'b1, f, s};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (4) @(posedge clk);
      #1;
      // R1: state while in reset
      check({link_up, full_duplex, speed, update, mdio_req} == 6'b0, "R1 reset outputs",
            {link_up, full_duplex, speed, update, mdio_req}, 0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      check({link_up, full_duplex, speed, update, mdio_req} == 6'b0, "R1 after reset",
            {link_up, full_duplex, speed, update, mdio_req}, 0);

      // standard layout sweep: R4 R5 R6 R10
      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 2; d++)
            for (int rs = 0; rs < 2; rs++)
               for (int an = 0; an < 2; an++) begin
                  phy_r17 = 16'((s << 14) | (d << 13) | (rs << 11) | 16'h0155);
                  phy_r0  = 16'((an << 12) | 16'h0100);
                  settle();
                  if (rs == 1 || an == 0)
                     check(snap_out == exp_std(phy_r17, phy_r0), "R6 resolved decode",
                           snap_out, exp_std(phy_r17, phy_r0));
                  else
                     check(snap_out == 4'h0, "R5 unresolved down", snap_out, 0);
                  check(snap_r0 == 5'd17 && snap_n == (rs ? 1 : 2), "R4 read count",
                        snap_n, rs ? 1 : 2);
                  if (rs == 0)
                     check(snap_r1 == 5'd0, "R4 second read is register 0", snap_r1, 0);
               end
      check(seen_bus == 8'h3A && seen_phy == 8'h05, "R3 bus and phy fields",
            {seen_bus, seen_phy}, 16'h3A05);
      cfg_phy_addr = 16'hC11F;
      settle();
      check(seen_bus == 8'hC1 && seen_phy == 8'h1F, "R3 bus and phy fields",
            {seen_bus, seen_phy}, 16'hC11F);

      // alternate layout: R7 R10
      cfg_alt_layout = 1'b1;
      for (int c = 0; c < 8; c++) begin
         phy_r25 = 16'((c << 8) | (16'h48F3 & ~16'h0700));
         settle();
         check(snap_out == exp_alt(c), "R7 alt decode", snap_out, exp_alt(c));
         check(snap_n == 1 && snap_r0 == 5'd25, "R7 single read of register 25", snap_r0, 25);
         if (c == 0) check(snap_out == 4'h0, "R10 down is all zero", snap_out, 0);
      end
      cfg_alt_layout = 1'b0;

      // no PHY: R8 R9
      cfg_no_phy = 1'b1;
      for (int en = 0; en < 2; en++)
         for (int st = 0; st < 2; st++)
            for (int dx = 0; dx < 2; dx++)
               for (int sp = 0; sp < 4; sp++) begin
                  logic [3:0] e;
                  cfg_inband_en = en[0]; ib_link = st[0]; ib_duplex = dx[0]; ib_speed = sp[1:0];
                  e = (en == 1 && st == 1 && sp != 3) ? {1'b1, dx[0], sp[1:0]} : 4'h0;
                  settle();
                  check(snap_out == e, en ? "R8 in-band copy" : "R9 no in-band down", snap_out, e);
                  check(snap_n == 0, "R9 no read without PHY", snap_n, 0);
               end

      // R2: idle spacing is interval+1
      cfg_interval = 8'd7;
      settle();
      wait_upd();
      check(upd_gap == 8, "R2 idle poll spacing", int'(upd_gap), 8);

      // R2: busy polls drop ticks, spacing a multiple of interval+1
      cfg_no_phy = 1'b0;
      cfg_interval = 8'd3;
      lat = 6;
      phy_r17 = 16'hA800;
      phy_r0  = 16'h1000;
      settle();
      for (int k = 0; k < 6; k++) begin
         wait_upd();
         check(upd_gap > 4 && (upd_gap % 4) == 0, "R2 busy spacing", int'(upd_gap), 8);
      end
      check(snap_out == exp_std(phy_r17, phy_r0), "R6 decode under slow replies",
            snap_out, exp_std(phy_r17, phy_r0));

      check(overlap_viol == 0, "R3 one outstanding read", overlap_viol, 0);
      check(pulse_viol == 0, "R11 single-cycle update", pulse_viol, 0);
      check(hold_viol == 0, "R11 outputs hold between updates", hold_viol, 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule